// File: doc/BRIEF.md
# Block-Lock Write Permission Gate

This block judges every write that a serial memory controller is about to start. The target is either a byte address in the nonvolatile data array or the nonvolatile fields of the status register. The block takes five inputs: the write-enable latch, the status-lock enable bit, the level of the hardware write-protect pin, a two-bit lock code, and the target address. When the controller pulses `wr_start`, the block registers a verdict and holds it until the next pulse.

The lock code fences off a region at the top of the address space. Code 0 fences nothing, code 1 the upper quarter, code 2 the upper half and code 3 the whole array. Nothing inside that region can be written, whatever the other inputs are. The status fields are refused when the enable bit is set and the pin is low. The block also gives the status-write path a bit mask, so that the flag, latch and busy bits can never be changed through it. It raises a one-cycle pulse so the caller can clear its write-enable latch, but only when a write was accepted.

Top module: `blk_guard`

## Requirements
- R1: After a synchronous reset, `arr_ok`, `sts_ok`, `wel_clr` are 0 and `sts_mask` is 8'h00.
- R2: A write started with `wel_in`=0 is refused for both the array and the status fields.
- R3: With `wel_in`=1, `lock_en`=1 and `wp_lvl`=0, a status write is refused and an array write outside the locked region is accepted.
- R4: With `wel_in`=1 and either `lock_en`=0 or `wp_lvl`=1, both a status write and an array write outside the locked region are accepted.
- R5: `lock_code` fences addresses as follows: 0 fences none, 1 fences 0x600–0x7FF, 2 fences 0x400–0x7FF, 3 fences 0x000–0x7FF. A fenced address is always refused.
- R6: The verdict appears in the cycle after the clock edge that samples `wr_start`=1. It holds unchanged while `wr_start` stays 0, even if the other inputs change.
- R7: When a status write is accepted, `sts_mask` is 8'hBC: the lock-enable bit 7, watchdog bits 5:4 and lock code bits 3:2. Otherwise it is 8'h00. Bits 6 (flag), 1 (latch) and 0 (busy) are never set.
- R8: `wel_clr` pulses high for exactly one cycle alongside an accepted verdict. After a refused write it stays low, so a refused page write leaves the latch unchanged.
- R9: `arr_ok` is only set for an array target (`tgt_sts`=0) and `sts_ok` only for a status target. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Samples the inputs and registers a verdict |
| wel_in | input | 1 | Write-enable latch state |
| lock_en | input | 1 | Nonvolatile status-lock enable bit |
| wp_lvl | input | 1 | Write-protect pin level (low locks status) |
| lock_code | input | 2 | Block-lock region code |
| tgt_sts | input | 1 | 1 = status write, 0 = array write |
| tgt_addr | input | 11 | Array byte (page start) address |
| arr_ok | output | 1 | Array write permitted |
| sts_ok | output | 1 | Status write permitted |
| sts_mask | output | 8 | Status bits the write may change |
| wel_clr | output | 1 | One-cycle pulse: clear write-enable latch |

## Verification
A wrong region decode shows up as a wrong `arr_ok` on the cycle right after `wr_start`, but only for addresses near a fence boundary. For this reason the truth table probes addresses just either side of 0x400 and 0x600 under every lock code. A wrong permission term shows up as a wrong `sts_ok` or `arr_ok` on the same cycle, for some combination of latch, enable bit and pin. The exhaustive sweep covers every combination. A verdict register that reloads without a strobe is caught when the inputs are changed with `wr_start` low. A stuck or stretched `wel_clr` is caught one cycle later.

// File: rtl/blk_guard_pkg.sv
package blk_guard_pkg;
  typedef enum logic [1:0] {
    LOCK_NONE = 2'd0,
    LOCK_QTR  = 2'd1,
    LOCK_HALF = 2'd2,
    LOCK_ALL  = 2'd3
  } lock_e;

  localparam int SR_W       = 8;
  localparam int SR_LOCKEN  = 7;
  localparam int SR_WDHI    = 5;
  localparam int SR_WDLO    = 4;
  localparam int SR_LCHI    = 3;
  localparam int SR_LCLO    = 2;

  function automatic logic [SR_W-1:0] sts_field_mask();
    logic [SR_W-1:0] m;
    m = '0;
    m[SR_LOCKEN] = 1'b1;
    m[SR_WDHI]   = 1'b1;
    m[SR_WDLO]   = 1'b1;
    m[SR_LCHI]   = 1'b1;
    m[SR_LCLO]   = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/blk_region_dec.sv
module blk_region_dec #(
  parameter int AW = 11
) (
  input  blk_guard_pkg::lock_e code,
  input  logic [AW-1:0]        addr,
  output logic                 fenced
);
  import blk_guard_pkg::*;

  always_comb begin
    unique case (code)
      LOCK_NONE: fenced = 1'b0;
      LOCK_QTR:  fenced = &addr[AW-1:AW-2];
      LOCK_HALF: fenced = addr[AW-1];
      default:   fenced = 1'b1;
    endcase
  end
endmodule

// File: rtl/blk_permit.sv
module blk_permit (
  input  logic wel,
  input  logic lock_en,
  input  logic wp_lvl,
  input  logic fenced,
  input  logic to_sts,
  output logic arr_perm,
  output logic sts_perm
);
  logic sts_locked;

  always_comb begin
    sts_locked = lock_en & ~wp_lvl;
    arr_perm   = wel & ~to_sts & ~fenced;
    sts_perm   = wel & to_sts & ~sts_locked;
  end
endmodule

// File: rtl/blk_guard.sv
module blk_guard #(
  parameter int AW = 11,
  parameter int SW = blk_guard_pkg::SR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_start,
  input  logic          wel_in,
  input  logic          lock_en,
  input  logic          wp_lvl,
  input  logic [1:0]    lock_code,
  input  logic          tgt_sts,
  input  logic [AW-1:0] tgt_addr,
  output logic          arr_ok,
  output logic          sts_ok,
  output logic [SW-1:0] sts_mask,
  output logic          wel_clr
);
  import blk_guard_pkg::*;

  localparam logic [SW-1:0] FIELD_MASK = SW'(sts_field_mask());

  logic fenced;
  logic arr_perm;
  logic sts_perm;

  blk_region_dec #(.AW(AW)) u_dec (
    .code   (lock_e'(lock_code)),
    .addr   (tgt_addr),
    .fenced (fenced)
  );

  blk_permit u_perm (
    .wel      (wel_in),
    .lock_en  (lock_en),
    .wp_lvl   (wp_lvl),
    .fenced   (fenced),
    .to_sts   (tgt_sts),
    .arr_perm (arr_perm),
    .sts_perm (sts_perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_ok   <= 1'b0;
      sts_ok   <= 1'b0;
      sts_mask <= '0;
      wel_clr  <= 1'b0;
    end else begin
      wel_clr <= 1'b0;
      if (wr_start) begin
        arr_ok   <= arr_perm;
        sts_ok   <= sts_perm;
        sts_mask <= sts_perm ? FIELD_MASK : '0;
        wel_clr  <= arr_perm | sts_perm;
      end
    end
  end
endmodule

// File: rtl/blk_guard_chk.sv
module blk_guard_chk #(
  parameter int AW = 11,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_start,
  input logic          wel_in,
  input logic          lock_en,
  input logic          wp_lvl,
  input logic [1:0]    lock_code,
  input logic          tgt_sts,
  input logic [AW-1:0] tgt_addr,
  input logic          arr_ok,
  input logic          sts_ok,
  input logic [SW-1:0] sts_mask,
  input logic          wel_clr
);
  a_r2_no_latch_no_write: assert property (@(posedge clk) disable iff (rst)
    (wr_start && !wel_in) |=> (!arr_ok && !sts_ok));

  a_r3_status_pin_lock: assert property (@(posedge clk) disable iff (rst)
    (wr_start && tgt_sts && lock_en && !wp_lvl) |=> !sts_ok);

  a_r5_full_lock: assert property (@(posedge clk) disable iff (rst)
    (wr_start && !tgt_sts && lock_code == 2'd3) |=> !arr_ok);

  a_r5_quarter_lock: assert property (@(posedge clk) disable iff (rst)
    (wr_start && lock_code == 2'd1 && tgt_addr[AW-1:AW-2] == 2'b11) |=> !arr_ok);

  a_r6_hold_arr: assert property (@(posedge clk) disable iff (rst)
    !wr_start |=> ($stable(arr_ok) && $stable(sts_ok)));

  a_r7_mask_follows: assert property (@(posedge clk) disable iff (rst)
    (!sts_ok |-> sts_mask == '0) and (sts_ok |-> sts_mask[6] == 1'b0 && sts_mask[1:0] == 2'b00));

  a_r8_clr_only_on_accept: assert property (@(posedge clk) disable iff (rst)
    wel_clr |-> (arr_ok || sts_ok));

  a_r8_clr_single: assert property (@(posedge clk) disable iff (rst)
    (wel_clr && !wr_start) |=> !wel_clr);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_ok, sts_ok}));
endmodule

bind blk_guard blk_guard_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .wr_start(wr_start), .wel_in(wel_in),
  .lock_en(lock_en), .wp_lvl(wp_lvl), .lock_code(lock_code),
  .tgt_sts(tgt_sts), .tgt_addr(tgt_addr), .arr_ok(arr_ok),
  .sts_ok(sts_ok), .sts_mask(sts_mask), .wel_clr(wel_clr)
);

// File: tb/blk_guard_test.sv
module blk_guard_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_start;
  logic        wel_in, lock_en, wp_lvl, tgt_sts;
  logic [1:0]  lock_code;
  logic [10:0] tgt_addr;
  logic        arr_ok, sts_ok, wel_clr;
  logic [7:0]  sts_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  blk_guard uut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wel_in(wel_in),
    .lock_en(lock_en), .wp_lvl(wp_lvl), .lock_code(lock_code),
    .tgt_sts(tgt_sts), .tgt_addr(tgt_addr), .arr_ok(arr_ok),
    .sts_ok(sts_ok), .sts_mask(sts_mask), .wel_clr(wel_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_fenced(input logic [1:0] c, input int a);
    case (c)
      2'd0: return 0;
      2'd1: return a >= 'h600;
      2'd2: return a >= 'h400;
      default: return 1;
    endcase
  endfunction

  task automatic apply(input bit w, input bit e, input bit p, input logic [1:0] c,
                       input bit s, input int a);
    @(negedge clk);
    wel_in = w; lock_en = e; wp_lvl = p; lock_code = c; tgt_sts = s;
    tgt_addr = 11'(a); wr_start = 1'b1;
    @(negedge clk);
    wr_start = 1'b0;
  endtask

  task automatic test_reset();
    rst = 1'b1; wr_start = 1'b0; wel_in = 1'b1; lock_en = 0; wp_lvl = 1;
    lock_code = 0; tgt_sts = 0; tgt_addr = 0;
    repeat (3) @(negedge clk);
    chk("R1 arr_ok", arr_ok, 0);
    chk("R1 sts_ok", sts_ok, 0);
    chk("R1 sts_mask", sts_mask, 0);
    chk("R1 wel_clr", wel_clr, 0);
    rst = 1'b0;
  endtask

  task automatic test_table();
    int addrs[8] = '{'h000, 'h123, 'h3FF, 'h400, 'h5FF, 'h600, 'h7E0, 'h7FF};
    for (int w = 0; w < 2; w++)
      for (int e = 0; e < 2; e++)
        for (int p = 0; p < 2; p++)
          for (int c = 0; c < 4; c++)
            for (int s = 0; s < 2; s++)
              for (int k = 0; k < 8; k++) begin
                bit exp_a, exp_s;
                exp_a = (w == 1) && (s == 0) && !model_fenced(2'(c), addrs[k]);
                exp_s = (w == 1) && (s == 1) && !(e == 1 && p == 0);
                apply(w[0], e[0], p[0], 2'(c), s[0], addrs[k]);
                chk("R2/R3/R4/R5/R9 arr_ok", arr_ok, exp_a);
                chk("R2/R3/R4/R9 sts_ok", sts_ok, exp_s);
                chk("R7 sts_mask", sts_mask, exp_s ? 'hBC : 0);
                chk("R8 wel_clr", wel_clr, exp_a | exp_s);
              end
  endtask

  task automatic test_hold();
    apply(1, 0, 1, 2'd0, 0, 'h010);
    chk("R6 accepted", arr_ok, 1);
    @(negedge clk);
    wel_in = 0; lock_code = 2'd3; tgt_addr = 11'h7FF;
    chk("R8 pulse one cycle", wel_clr, 0);
    repeat (2) @(negedge clk);
    chk("R6 hold arr_ok", arr_ok, 1);
    chk("R6 hold sts_ok", sts_ok, 0);
    apply(1, 1, 1, 2'd2, 0, 'h400);
    chk("R8 rejected page no clear", wel_clr, 0);
    chk("R5 half fence 0x400", arr_ok, 0);
  endtask

  initial begin
    test_reset();
    test_table();
    test_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule